// File: doc/BRIEF.md
# Outstanding Transaction Limit Monitor

This block watches the request and completion pulses of a bus master and keeps a running count of how many transactions have been issued but not yet finished. A request and a completion in the same cycle cancel out. When the master issues a new request while the count already sits at the allowed maximum, the block reports an overflow. When a completion arrives while nothing is outstanding, it reports an underflow. In both cases the error is tied to the cycle that carried the illegal pulse, not to a later cycle in which the count would already be out of range.

The block is a synthesizable runtime checker. It can sit beside a master in silicon or in an emulation build. The maximum is a parameter with a default of 4, and the counter is exactly as wide as that maximum needs. Each error has two outputs: a one-cycle registered pulse and a sticky flag that stays set until reset.

Top module: `outstanding_limit_monitor`

## Requirements
- R1: `occ_count` never exceeds `LIMIT` (default 4). Its width is the smallest number of bits that can hold `LIMIT`.
- R2: When `req` is high, `done` is low and the count is below `LIMIT`, the count is one higher after the next rising clock edge.
- R3: When `done` is high, `req` is low and the count is above zero, the count is one lower after the next rising clock edge.
- R4: When `req` and `done` are both high, or both low, the count is unchanged after the edge, whatever its value.
- R5: When `req` is high, `done` is low and the count equals `LIMIT`, `ovf_pulse` is high for exactly the following cycle and the count stays at `LIMIT`. In every other case `ovf_pulse` is low.
- R6: When `done` is high, `req` is low and the count is zero, `unf_pulse` is high for exactly the following cycle and the count stays at zero. In every other case `unf_pulse` is low.
- R7: `ovf_sticky` and `unf_sticky` are set in the same cycle as their pulse and stay high until reset.
- R8: While `rst_n` is low, all outputs are zero, independent of the clock. Reset acts asynchronously.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | 1 | One-cycle pulse: a transaction is issued |
| done | input | 1 | One-cycle pulse: a transaction completes |
| occ_count | output | $clog2(LIMIT+1) | Number of transactions currently outstanding |
| ovf_pulse | output | 1 | Registered pulse: issue attempted at the limit |
| unf_pulse | output | 1 | Registered pulse: completion with nothing outstanding |
| ovf_sticky | output | 1 | Overflow seen since reset |
| unf_sticky | output | 1 | Underflow seen since reset |

## Verification
The assertions assume that `req` and `done` are never unknown at a rising edge. They also assume both inputs are held low around every reset release, so that the first sampled history after reset describes a quiet cycle. The bench changes inputs only on falling edges and forces both low whenever it drives reset. Apart from that the pulses are unconstrained, so the bench can deliberately produce the illegal issue and completion patterns the block is meant to detect.

// File: rtl/olm_pkg.sv
package olm_pkg;

    // Classification of one cycle of req/done against the current occupancy.
    typedef struct packed {
        logic grow;    // legal issue
        logic shrink;  // legal completion
        logic over;    // issue while at the limit
        logic under;   // completion while empty
    } olm_event_t;

    localparam int unsigned ERR_KINDS = 2;
    localparam int unsigned ERR_OVF   = 0;
    localparam int unsigned ERR_UNF   = 1;

endpackage

// File: rtl/olm_classify.sv
module olm_classify
    import olm_pkg::*;
#(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             req,
    input  logic             done,
    input  logic [CNT_W-1:0] count,
    output olm_event_t       evt
);

    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    logic issue_only;
    logic retire_only;
    logic at_limit;
    logic empty;

    always_comb begin
        issue_only  = req && !done;
        retire_only = done && !req;
        at_limit    = (count == LIM_C);
        empty       = (count == '0);

        evt.grow    = issue_only  && !at_limit;
        evt.over    = issue_only  &&  at_limit;
        evt.shrink  = retire_only && !empty;
        evt.under   = retire_only &&  empty;
    end

endmodule

// File: rtl/olm_counter.sv
module olm_counter
    import olm_pkg::*;
#(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  olm_event_t       evt,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] occ;
    } cnt_state_t;

    cnt_state_t st_d;
    cnt_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (evt.grow) begin
            st_d.occ = st_q.occ + CNT_W'(1);
        end else if (evt.shrink) begin
            st_d.occ = st_q.occ - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count = st_q.occ;

endmodule

// File: rtl/olm_flags.sv
module olm_flags
    import olm_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ERR_KINDS-1:0] hit,
    output logic [ERR_KINDS-1:0] pulse,
    output logic [ERR_KINDS-1:0] sticky
);

    typedef struct packed {
        logic pls;
        logic stk;
    } flag_state_t;

    for (genvar k = 0; k < ERR_KINDS; k++) begin : g_kind
        flag_state_t fl_d;
        flag_state_t fl_q;

        always_comb begin
            fl_d.pls = hit[k];
            fl_d.stk = fl_q.stk | hit[k];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                fl_q <= '0;
            end else begin
                fl_q <= fl_d;
            end
        end

        assign pulse[k]  = fl_q.pls;
        assign sticky[k] = fl_q.stk;
    end

endmodule

// File: rtl/outstanding_limit_monitor.sv
module outstanding_limit_monitor
    import olm_pkg::*;
#(
    parameter int unsigned LIMIT = 4,
    localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             done,
    output logic [CNT_W-1:0] occ_count,
    output logic             ovf_pulse,
    output logic             unf_pulse,
    output logic             ovf_sticky,
    output logic             unf_sticky
);

    olm_event_t           evt;
    logic [ERR_KINDS-1:0] err_hit;
    logic [ERR_KINDS-1:0] err_pulse;
    logic [ERR_KINDS-1:0] err_sticky;

    olm_classify #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_classify (
        .req   (req),
        .done  (done),
        .count (occ_count),
        .evt   (evt)
    );

    olm_counter #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .evt   (evt),
        .count (occ_count)
    );

    always_comb begin
        err_hit          = '0;
        err_hit[ERR_OVF] = evt.over;
        err_hit[ERR_UNF] = evt.under;
    end

    olm_flags u_flags (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit    (err_hit),
        .pulse  (err_pulse),
        .sticky (err_sticky)
    );

    assign ovf_pulse  = err_pulse[ERR_OVF];
    assign unf_pulse  = err_pulse[ERR_UNF];
    assign ovf_sticky = err_sticky[ERR_OVF];
    assign unf_sticky = err_sticky[ERR_UNF];

endmodule

// File: rtl/olm_checker.sv
module olm_checker #(
    parameter int unsigned LIMIT = 4,
    parameter int unsigned CNT_W = $clog2(LIMIT + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req,
    input logic             done,
    input logic [CNT_W-1:0] occ_count,
    input logic             ovf_pulse,
    input logic             unf_pulse,
    input logic             ovf_sticky,
    input logic             unf_sticky
);

    localparam logic [CNT_W-1:0] LIM_C = CNT_W'(LIMIT);

    logic bad_issue;
    logic bad_retire;
    assign bad_issue  = req && !done && (occ_count == LIM_C);
    assign bad_retire = done && !req && (occ_count == '0);

    assert_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        occ_count <= LIM_C);

    assert_grow_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !done && occ_count != LIM_C) |=> occ_count == $past(occ_count) + CNT_W'(1));

    assert_shrink_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !req && occ_count != '0) |=> occ_count == $past(occ_count) - CNT_W'(1));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req == done) |=> $stable(occ_count));

    assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        bad_issue |=> ovf_pulse && occ_count == LIM_C);

    assert_quiet_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_issue |=> !ovf_pulse);

    assert_no_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        bad_retire |=> unf_pulse && occ_count == '0);

    assert_quiet_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bad_retire |=> !unf_pulse);

    assert_ovf_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_sticky |=> ovf_sticky);

    assert_unf_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_sticky |=> unf_sticky);

    assert_ovf_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_pulse |-> ovf_sticky);

    assert_unf_cover_R7: assert property (@(posedge clk) disable iff (!rst_n)
        unf_pulse |-> unf_sticky);

endmodule

bind outstanding_limit_monitor olm_checker #(.LIMIT(LIMIT), .CNT_W(CNT_W)) u_olm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .done       (done),
    .occ_count  (occ_count),
    .ovf_pulse  (ovf_pulse),
    .unf_pulse  (unf_pulse),
    .ovf_sticky (ovf_sticky),
    .unf_sticky (unf_sticky)
);

// File: tb/outstanding_limit_monitor_bench.sv
`timescale 1ns/1ps
module outstanding_limit_monitor_bench;

    localparam int unsigned LIMIT = 4;
    localparam int unsigned CNT_W = $clog2(LIMIT + 1);

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req = 1'b0;
    logic             done = 1'b0;
    logic [CNT_W-1:0] occ_count;
    logic             ovf_pulse;
    logic             unf_pulse;
    logic             ovf_sticky;
    logic             unf_sticky;

    int checks = 0;
    int fails  = 0;
    bit ended  = 1'b0;

    // behavioural reference state
    int    m_cnt = 0;
    bit    m_ovf = 0, m_unf = 0, m_ovf_s = 0, m_unf_s = 0;
    string m_tag = "R8";

    always #2.5 clk = ~clk;

    outstanding_limit_monitor #(.LIMIT(LIMIT)) u_outstanding_limit_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .req        (req),
        .done       (done),
        .occ_count  (occ_count),
        .ovf_pulse  (ovf_pulse),
        .unf_pulse  (unf_pulse),
        .ovf_sticky (ovf_sticky),
        .unf_sticky (unf_sticky)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic compare();
        chk("R1", "count bound", (int'(occ_count) <= LIMIT) ? 1 : 0, 1);
        chk(m_tag, "count", int'(occ_count), m_cnt);
        chk(m_tag == "R5" ? "R5" : "R5(idle)", "ovf_pulse", int'(ovf_pulse), int'(m_ovf));
        chk(m_tag == "R6" ? "R6" : "R6(idle)", "unf_pulse", int'(unf_pulse), int'(m_unf));
        chk("R7", "ovf_sticky", int'(ovf_sticky), int'(m_ovf_s));
        chk("R7", "unf_sticky", int'(unf_sticky), int'(m_unf_s));
    endtask

    task automatic model_step(input bit r, input bit d);
        m_ovf = 0;
        m_unf = 0;
        if (r && !d) begin
            if (m_cnt == LIMIT) begin m_ovf = 1; m_tag = "R5"; end
            else begin m_cnt++; m_tag = "R2"; end
        end else if (d && !r) begin
            if (m_cnt == 0) begin m_unf = 1; m_tag = "R6"; end
            else begin m_cnt--; m_tag = "R3"; end
        end else begin
            m_tag = "R4";
        end
        m_ovf_s = m_ovf_s | m_ovf;
        m_unf_s = m_unf_s | m_unf;
    endtask

    // one clock: check what the last edge produced, then present new inputs
    task automatic cyc(input bit r, input bit d);
        @(negedge clk);
        compare();
        req  = r;
        done = d;
        model_step(r, d);
    endtask

    task automatic do_reset();
        @(negedge clk);
        req   = 1'b0;
        done  = 1'b0;
        rst_n = 1'b0;
        #1;
        // R8: asynchronous clear, visible before any clock edge
        chk("R8", "count in reset", int'(occ_count), 0);
        chk("R8", "flags in reset", int'({ovf_pulse, unf_pulse, ovf_sticky, unf_sticky}), 0);
        m_cnt = 0; m_ovf = 0; m_unf = 0; m_ovf_s = 0; m_unf_s = 0; m_tag = "R8";
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #(5ns * 20000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual hung expected completion");
        finish_run();
    end

    initial begin
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        cyc(0, 0);                                   // R8 reset values checked here
        for (int i = 0; i < LIMIT; i++) cyc(1, 0);   // R2 fill to limit
        cyc(1, 0);                                   // R5 fifth issue
        cyc(0, 0);
        cyc(1, 1);                                   // R4 both at limit
        cyc(1, 1);
        for (int i = 0; i < LIMIT; i++) cyc(0, 1);   // R3 drain
        cyc(0, 1);                                   // R6 completion while empty
        cyc(1, 1);                                   // R4 both while empty
        cyc(0, 0);
        cyc(1, 0); cyc(1, 1); cyc(0, 1); cyc(0, 0);  // mixed
        for (int i = 0; i < 3000; i++) cyc(1'($urandom), 1'($urandom));
        do_reset();                                  // R8 sticky cleared mid-run
        cyc(0, 0);
        cyc(0, 1);                                   // R6 again after reset
        for (int i = 0; i < LIMIT + 2; i++) cyc(1, 0);  // R5 repeated at limit
        cyc(0, 0);
        cyc(0, 0);
        finish_run();
    end

endmodule